// File: doc/BRIEF.md
# Sampled Trigger and Timestamp Unit

This block sits in front of a capture memory in a small logic analyser. It runs entirely on the system clock. A programmable divisor paces a single-cycle sample strobe, which is an enable and never a clock. On each strobe the multi-channel input word is registered. If the new word differs from the one before it, a one-cycle event pulse is raised. One selectable channel is watched for a rising or falling edge, and when that edge is seen a triggered flag latches.

Alongside the samples, an 8-bit relative timestamp counts strobes since the last change. A change restarts the count at 1. When the count would pass its maximum, an overflow pulse tells the downstream writer to open a new entry even though nothing changed. As a result only changes, plus periodic overflow markers, need storing. Dropping the enable returns the unit to its idle state, ready for the next capture.

Top module: `sample_event_unit`

## Requirements
- R1: While enabled, `strobe_o` is high for one clock out of every `div_i` clocks. The first strobe comes `div_i` clocks after enable rises. A `div_i` of 0 or 1 gives a strobe on every clock.
- R2: `sample_o` takes the value of `din_i` at the clock edge of a strobe cycle and holds it on every other enabled edge.
- R3: `event_o` is high for the one cycle after a strobe edge whose captured word differs from the previous captured word. The first strobe after enable never raises it.
- R4: With `edge_i` = 1 (rising), `trig_o` sets when channel `sel_i` was 0 in the previous strobed sample and is 1 in the new one. With `edge_i` = 0 (falling), it sets on 1 followed by 0.
- R5: Once set, `trig_o` stays high for as long as `en_i` stays high, whatever the later input edges.
- R6: A strobe that brings no change and no wrap increments `stamp_o` by one.
- R7: A strobe that brings a change sets `stamp_o` to 1.
- R8: A strobe that finds `stamp_o` at 255 with no change sets `stamp_o` to 1 and raises `ovf_o` for one cycle. `stamp_o` is never 0.
- R9: While `en_i` is low, there is no strobe, `stamp_o` is 1, and `trig_o`, `event_o`, `ovf_o` and `sample_o` are 0.
- R10: During reset, the outputs take the idle values listed in R9.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en_i | input | 1 | Capture enable |
| div_i | input | 16 | Sample divisor |
| sel_i | input | 3 | Index of the channel watched for the trigger |
| edge_i | input | 1 | Trigger edge: 1 rising, 0 falling |
| din_i | input | 8 | Channel input word |
| strobe_o | output | 1 | One-cycle sample strobe |
| event_o | output | 1 | Pulse: new sample differs from the previous one |
| ovf_o | output | 1 | Pulse: timestamp wrapped without a change |
| stamp_o | output | 8 | Relative timestamp, 1 to 255 |
| sample_o | output | 8 | Last captured sample |
| trig_o | output | 1 | Latched trigger flag |

## Verification
A wrong divisor count moves `strobe_o` on the very next clock. It also moves the capture instants, so `sample_o` and `stamp_o` drift from the reference within one sample period. A stale copy of the previous sample misfires `event_o` or `trig_o` one cycle after the next strobe. A timestamp that wraps through 0 or skips the reset-to-1 step is visible on `stamp_o` at the very next strobe. An idle state that is not cleared appears as a leftover `trig_o` or as a missing event on the first strobes after re-enable.

// File: rtl/seu_pkg.sv
package seu_pkg;

    typedef enum logic {
        EDGE_FALL = 1'b0,
        EDGE_RISE = 1'b1
    } edge_kind_t;

    // True when the watched bit moved in the requested direction
    function automatic logic edge_hit(logic prev, logic cur, edge_kind_t kind);
        return (kind == EDGE_RISE) ? (!prev && cur) : (prev && !cur);
    endfunction

endpackage

// File: rtl/seu_strobe_gen.sv
module seu_strobe_gen #(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_i,
    input  logic [DIV_W-1:0] div_i,
    output logic             strobe_o
);

    typedef struct packed {
        logic [DIV_W-1:0] cnt;
    } gen_state_t;

    gen_state_t s_d, s_q;
    logic       fire;

    always_comb begin
        fire = en_i && ((div_i <= DIV_W'(1)) || (s_q.cnt >= div_i - DIV_W'(1)));
        s_d  = s_q;
        if (!en_i || fire) begin
            s_d.cnt = '0;
        end else begin
            s_d.cnt = s_q.cnt + DIV_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign strobe_o = fire;

    // R1: with a steady divisor above one, strobes never come back to back
    p_single_pulse_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe_o && div_i > DIV_W'(1)) |=> (!strobe_o || !$stable(div_i)));

    // R9: no strobe while capture is off
    p_no_strobe_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |-> !strobe_o);

endmodule

// File: rtl/seu_sampler.sv
module seu_sampler
    import seu_pkg::*;
#(
    parameter int NCH   = 8,
    parameter int SEL_W = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_i,
    input  logic             strobe_i,
    input  logic [NCH-1:0]   din_i,
    input  logic [SEL_W-1:0] sel_i,
    input  logic             edge_i,
    output logic             chg_o,
    output logic [NCH-1:0]   sample_o,
    output logic             event_o,
    output logic             trig_o
);

    typedef struct packed {
        logic [NCH-1:0] smp;
        logic           valid;
        logic           trig;
        logic           evt;
    } smp_state_t;

    smp_state_t s_d, s_q;
    logic       take;
    logic       chg;
    logic       hit;

    always_comb begin
        take = en_i && strobe_i;
        chg  = take && s_q.valid && (din_i != s_q.smp);
        hit  = take && s_q.valid &&
               edge_hit(s_q.smp[sel_i], din_i[sel_i], edge_kind_t'(edge_i));
        s_d  = s_q;
        if (!en_i) begin
            s_d = '0;
        end else begin
            s_d.evt  = chg;
            s_d.trig = s_q.trig || hit;
            if (take) begin
                s_d.smp   = din_i;
                s_d.valid = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign chg_o    = chg;
    assign sample_o = s_q.smp;
    assign event_o  = s_q.evt;
    assign trig_o   = s_q.trig;

    // R2: without a strobe the captured word stays put
    p_hold_sample_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && !strobe_i) |=> $stable(sample_o));

    // R3: an event always marks a word different from the one before it
    p_event_differs_r3: assert property (@(posedge clk) disable iff (!rst_n)
        event_o |-> (sample_o != $past(sample_o)));

    // R5: the trigger flag is sticky while enabled
    p_trig_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (trig_o && en_i) |=> trig_o);

endmodule

// File: rtl/seu_stamp.sv
module seu_stamp #(
    parameter int TS_W = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            en_i,
    input  logic            strobe_i,
    input  logic            chg_i,
    output logic [TS_W-1:0] stamp_o,
    output logic            ovf_o
);

    localparam logic [TS_W-1:0] TS_MAX = '1;
    localparam logic [TS_W-1:0] TS_ONE = TS_W'(1);

    typedef struct packed {
        logic [TS_W-1:0] ts;
        logic            ovf;
    } ts_state_t;

    ts_state_t s_d, s_q;

    always_comb begin
        s_d     = s_q;
        s_d.ovf = 1'b0;
        if (!en_i) begin
            s_d.ts = TS_ONE;
        end else if (strobe_i) begin
            if (chg_i) begin
                s_d.ts = TS_ONE;
            end else if (s_q.ts == TS_MAX) begin
                s_d.ts  = TS_ONE;
                s_d.ovf = 1'b1;
            end else begin
                s_d.ts = s_q.ts + TS_ONE;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.ts  <= TS_ONE;
            s_q.ovf <= 1'b0;
        end else begin
            s_q <= s_d;
        end
    end

    assign stamp_o = s_q.ts;
    assign ovf_o   = s_q.ovf;

    // R8: the timestamp never reads zero
    p_stamp_nonzero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        stamp_o != '0);

    // R7: a detected change restarts the count at one
    p_change_restart_r7: assert property (@(posedge clk) disable iff (!rst_n)
        chg_i |=> (stamp_o == TS_ONE));

    // R8: a wrap pulse follows a full count and leaves one behind
    p_wrap_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_o |-> (stamp_o == TS_ONE && $past(stamp_o) == TS_MAX));

endmodule

// File: rtl/sample_event_unit.sv
module sample_event_unit #(
    parameter int NCH   = 8,
    parameter int DIV_W = 16,
    parameter int TS_W  = 8,
    parameter int SEL_W = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_i,
    input  logic [DIV_W-1:0] div_i,
    input  logic [SEL_W-1:0] sel_i,
    input  logic             edge_i,
    input  logic [NCH-1:0]   din_i,
    output logic             strobe_o,
    output logic             event_o,
    output logic             ovf_o,
    output logic [TS_W-1:0]  stamp_o,
    output logic [NCH-1:0]   sample_o,
    output logic             trig_o
);

    logic strobe;
    logic chg;

    seu_strobe_gen #(
        .DIV_W (DIV_W)
    ) i_gen (
        .clk      (clk),
        .rst_n    (rst_n),
        .en_i     (en_i),
        .div_i    (div_i),
        .strobe_o (strobe)
    );

    seu_sampler #(
        .NCH   (NCH),
        .SEL_W (SEL_W)
    ) i_smp (
        .clk      (clk),
        .rst_n    (rst_n),
        .en_i     (en_i),
        .strobe_i (strobe),
        .din_i    (din_i),
        .sel_i    (sel_i),
        .edge_i   (edge_i),
        .chg_o    (chg),
        .sample_o (sample_o),
        .event_o  (event_o),
        .trig_o   (trig_o)
    );

    seu_stamp #(
        .TS_W (TS_W)
    ) i_ts (
        .clk      (clk),
        .rst_n    (rst_n),
        .en_i     (en_i),
        .strobe_i (strobe),
        .chg_i    (chg),
        .stamp_o  (stamp_o),
        .ovf_o    (ovf_o)
    );

    assign strobe_o = strobe;

    // R9: one disabled edge returns every output to idle
    p_idle_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |=> (stamp_o == TS_W'(1) && !trig_o && !event_o && !ovf_o && sample_o == '0));

    // R3: an event pulse only follows a strobe cycle
    p_event_after_strobe_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !strobe_o |=> !event_o);

endmodule

// File: tb/test_sample_event_unit.sv
`timescale 1ns/1ps
module test_sample_event_unit;

    localparam int NCH   = 8;
    localparam int DIV_W = 16;
    localparam int TS_W  = 8;
    localparam int SEL_W = 3;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             en = 1'b0;
    logic [DIV_W-1:0] div = '0;
    logic [SEL_W-1:0] sel = '0;
    logic             rise = 1'b1;
    logic [NCH-1:0]   din = '0;
    logic             strobe, evt, ovf, trig;
    logic [TS_W-1:0]  stamp;
    logic [NCH-1:0]   sample;

    int checks = 0;
    int errors = 0;

    sample_event_unit #(.NCH(NCH), .DIV_W(DIV_W), .TS_W(TS_W), .SEL_W(SEL_W)) i_sample_event_unit (
        .clk(clk), .rst_n(rst_n), .en_i(en), .div_i(div), .sel_i(sel), .edge_i(rise),
        .din_i(din), .strobe_o(strobe), .event_o(evt), .ovf_o(ovf), .stamp_o(stamp),
        .sample_o(sample), .trig_o(trig)
    );

    always #2.5 clk = ~clk;

    typedef struct {
        logic [NCH-1:0]  smp;
        logic            evt;
        logic            ovf;
        logic            trig;
        logic [TS_W-1:0] ts;
    } exp_t;

    exp_t exp_q[$];

    // reference state built from the requirements
    logic [DIV_W-1:0] m_cnt = '0;
    logic [NCH-1:0]   m_smp = '0;
    logic             m_valid = 1'b0, m_trig = 1'b0, m_evt = 1'b0, m_ovf = 1'b0;
    logic [TS_W-1:0]  m_ts = 8'd1;

    task automatic check(input logic ok, input string req, input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, expv, $time);
        end
    endtask

    // driver side: advance the reference model each edge and queue its outputs
    always @(posedge clk) begin
        exp_t e;
        logic stb, chg;
        if (!rst_n || !en) begin
            m_cnt = '0; m_smp = '0; m_valid = 0; m_trig = 0; m_evt = 0; m_ovf = 0; m_ts = 8'd1;
        end else begin
            stb = (div <= 1) || (m_cnt >= div - 1);
            m_cnt = stb ? '0 : m_cnt + 1;
            m_evt = 0;
            m_ovf = 0;
            if (stb) begin
                chg = m_valid && (din != m_smp);
                if (m_valid && (rise ? (!m_smp[sel] && din[sel]) : (m_smp[sel] && !din[sel])))
                    m_trig = 1;
                m_evt = chg;
                if (chg) m_ts = 8'd1;
                else if (m_ts == 8'd255) begin m_ts = 8'd1; m_ovf = 1; end
                else m_ts = m_ts + 8'd1;
                m_smp = din;
                m_valid = 1;
            end
        end
        e.smp = m_smp; e.evt = m_evt; e.ovf = m_ovf; e.trig = m_trig; e.ts = m_ts;
        exp_q.push_back(e);
    end

    // monitor side: compare away from the active edge
    always @(negedge clk) begin
        exp_t e;
        logic exp_stb;
        if (exp_q.size() > 0) begin
            e = exp_q.pop_front();
            exp_stb = en && rst_n && ((div <= 1) || (m_cnt >= div - 1));
            check(strobe === exp_stb, "R1 strobe", int'(strobe), int'(exp_stb));
            check(sample === e.smp, "R2 sample", int'(sample), int'(e.smp));
            check(evt === e.evt, "R3 event", int'(evt), int'(e.evt));
            check(trig === e.trig, "R4 trigger", int'(trig), int'(e.trig));
            check(ovf === e.ovf, "R8 overflow", int'(ovf), int'(e.ovf));
            check(stamp === e.ts, "R6/R7 stamp", int'(stamp), int'(e.ts));
        end
    end

    logic [7:0] lfsr = 8'h5A;

    task automatic drive_random(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk); #1;
            lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
            if (lfsr[0] || lfsr[1]) din = lfsr ^ 8'h3C;
        end
    endtask

    task automatic step(input int n);
        for (int i = 0; i < n; i++) begin @(posedge clk); #1; end
    endtask

    initial begin
        #(5.0 * 60000);
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int ovf_seen;
        // R10: reset state
        repeat (3) @(negedge clk);
        check(stamp === 8'd1 && !trig && !evt && !ovf && sample === '0 && !strobe,
              "R10 reset idle", int'(stamp), 1);
        @(posedge clk); #1 rst_n = 1;

        // every-clock strobes, rising trigger on channel 2
        div = 16'd1; sel = 3'd2; rise = 1; en = 1;
        drive_random(200);

        // R4: explicit rising edge after re-enable
        en = 0; step(2);
        // R9: idle after disable
        @(negedge clk);
        check(stamp === 8'd1 && !trig && sample === '0 && !strobe, "R9 idle", int'(trig), 0);
        din = 8'h00; en = 1; step(3);
        @(negedge clk);
        check(!trig, "R4 no edge yet", int'(trig), 0);
        @(posedge clk); #1 din = 8'h04;
        @(posedge clk); @(negedge clk);
        check(trig === 1'b1, "R4 rising edge", int'(trig), 1);
        // R7: that change restarted the stamp
        check(stamp === 8'd1 && evt === 1'b1, "R7 change restart", int'(stamp), 1);
        // R5: later falling and rising edges leave the flag set
        @(posedge clk); #1 din = 8'h00;
        step(2); #1 din = 8'h04; step(2);
        @(negedge clk);
        check(trig === 1'b1, "R5 trigger held", int'(trig), 1);

        // R1: divisor 0 behaves like 1, falling trigger on channel 5
        en = 0; step(1); div = 16'd0; sel = 3'd5; rise = 0; en = 1;
        drive_random(150);

        // divisor 3 with inputs moving every clock
        en = 0; step(1); div = 16'd3; en = 1;
        drive_random(300);

        // R8: constant input, count two wraps
        en = 0; step(1); div = 16'd1; din = 8'hA5; en = 1;
        ovf_seen = 0;
        for (int i = 0; i < 600; i++) begin
            @(negedge clk);
            if (ovf) ovf_seen++;
        end
        check(ovf_seen == 2, "R8 wrap count", ovf_seen, 2);

        // R6: stamp climbs by one per strobe with divisor 4
        en = 0; step(1); div = 16'd4; en = 1;
        step(9);
        @(negedge clk);
        check(stamp === 8'd3, "R6 stamp climb", int'(stamp), 3);

        // divisor 5, rising trigger on channel 7
        en = 0; step(1); div = 16'd5; sel = 3'd7; rise = 1; en = 1;
        drive_random(400);

        step(2);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule